// File: doc/BRIEF.md
# Two-Parallel Fast FIR Filter

This block is a fixed-coefficient FIR filter that accepts two consecutive input samples on every clock and returns two filtered samples on every clock. The clock therefore runs at half the sample rate with no loss of throughput. The even sample x(2k) arrives on one lane and the following odd sample x(2k+1) on the other. Each output pair matches a plain M-tap direct-form filter sample for sample.

The work is shared by three sub-filters rather than by two full copies of the filter. Each sub-filter has ceil(M/2) taps. The first uses the even-indexed coefficients and the even lane. The second uses the odd-indexed coefficients and the odd lane. The third uses the pairwise coefficient sums and the sum of the two lanes. A pre-adder, a one-pair delay on the odd-coefficient result, and a few post-adders rebuild both outputs. The cost is about 3M/4 multiplications per sample instead of M.

All internal arithmetic runs at full precision, so the outputs are exact. The coefficients are fixed at elaboration time through a packed parameter. An input valid flag qualifies each pair. The filter history moves forward only on valid pairs.

Top module: `fir_two_parallel`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `out_valid` is 0 and both outputs read 0. All filter history starts at zero.
- R2: `out_valid` equals `in_valid` delayed by exactly two clocks, and each valid output pair belongs to the input pair presented two clocks earlier.
- R3: On a valid output, `y_even` equals sum over i of h(i)·x(2k−i), where samples before the first valid pair count as zero.
- R4: On a valid output, `y_odd` equals sum over i of h(i)·x(2k+1−i) under the same convention.
- R5: A cycle with `in_valid` low does not advance the history, and two clocks later both outputs keep their previous values. The next valid pair continues the sequence as if no gap had occurred.
- R6: Tap h(i) is the signed two's-complement field `COEFS[i*CW +: CW]`, and h(0) weights the newest sample. With an odd tap count, the missing highest odd-indexed coefficient counts as zero.
- R7: Results are exact over the full input and coefficient ranges, including every tap and every sample at its most negative value. The output width is DW+CW+ceil(log2(NTAPS)).
- R8: `x_even` carries the earlier sample of a pair and `x_odd` the later one. A unit sample on `x_odd` alone gives h(0) on `y_odd` of that pair, and h(i) lands on `y_odd`/`y_even` of later pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at half the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair qualifier |
| x_even | input | DW | Earlier sample x(2k), signed |
| x_odd | input | DW | Later sample x(2k+1), signed |
| out_valid | output | 1 | Output pair qualifier |
| y_even | output | DW+CW+ceil(log2(NTAPS)) | Filtered y(2k), signed |
| y_odd | output | DW+CW+ceil(log2(NTAPS)) | Filtered y(2k+1), signed |

## Verification
The hardest case to reach from the ports is the interaction of idle cycles with the cross-pair delay term. If an idle cycle updates that delay term or the sub-filter history, the wrong odd-coefficient result gets folded into the next even output. The error appears only when valid pairs resume. The stimulus mixes random idle gaps, including runs of several idle cycles, into long random sample streams, so that every resumed pair is compared against a reference built from valid samples only. Directed unit samples on each lane pin down the coefficient layout and the lane order. Runs of all-minimum and all-maximum samples drive the accumulators to their extremes.

// File: rtl/fir2p_pkg.sv
package fir2p_pkg;

  // number of taps in each of the three sub-filters
  function automatic int half_up(input int n);
    return (n + 1) / 2;
  endfunction

  // selector for which coefficient set a sub-filter uses
  localparam int SEL_EVEN = 0;
  localparam int SEL_ODD  = 1;
  localparam int SEL_SUM  = 2;

endpackage

// File: rtl/fir2p_subfir.sv
module fir2p_subfir
  import fir2p_pkg::*;
#(
  parameter int IW    = 13,
  parameter int CW    = 10,
  parameter int NTAPS = 9,
  parameter int SW    = 31,
  parameter int SEL   = 0,
  parameter logic [NTAPS*CW-1:0] COEFS = {NTAPS{CW'(1)}}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic signed [IW-1:0] x_in,
  output logic signed [SW-1:0] y_out
);
  localparam int T  = half_up(NTAPS);
  localparam int PW = 2 * T * CW;
  localparam int KW = CW + 1;
  localparam logic [PW-1:0] PAD = PW'(COEFS);

  logic signed [KW-1:0] kc   [T];
  logic signed [IW-1:0] hreg [T-1];
  logic signed [SW-1:0] acc;

  // per-tap coefficient for this sub-filter, one bit wider for the pair sum
  for (genvar j = 0; j < T; j++) begin : g_coef
    localparam logic signed [CW-1:0] HE = PAD[2*j*CW +: CW];
    localparam logic signed [CW-1:0] HO = PAD[(2*j+1)*CW +: CW];
    localparam logic signed [KW-1:0] HK =
      (SEL == SEL_EVEN) ? KW'(HE) :
      (SEL == SEL_ODD)  ? KW'(HO) : KW'(HE) + KW'(HO);
    assign kc[j] = HK;
  end

  // history advances only on qualified pairs
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < T-1; k++) hreg[k] <= '0;
    end else if (shift_en) begin
      hreg[0] <= x_in;
      for (int k = 1; k < T-1; k++) hreg[k] <= hreg[k-1];
    end
  end

  always_comb begin
    acc = SW'(kc[0]) * SW'(x_in);
    for (int j = 1; j < T; j++) acc = acc + SW'(kc[j]) * SW'(hreg[j-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) y_out <= '0;
    else     y_out <= acc;
  end

  initial begin
    assert_taps_R6: assert (T >= 2)
      else $error("sub-filter needs at least two taps");
  end

endmodule

// File: rtl/fir2p_recombine.sv
module fir2p_recombine #(
  parameter int SW = 31,
  parameter int YW = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 v_in,
  input  logic signed [SW-1:0] p_even,
  input  logic signed [SW-1:0] p_odd,
  input  logic signed [SW-1:0] p_sum,
  output logic                 v_out,
  output logic signed [YW-1:0] y_even,
  output logic signed [YW-1:0] y_odd
);
  localparam int WW = SW + 2;

  logic signed [SW-1:0] d_odd;
  logic signed [WW-1:0] w_even;
  logic signed [WW-1:0] w_odd;

  assign w_even = WW'(p_even) + WW'(d_odd);
  assign w_odd  = WW'(p_sum) - WW'(p_even) - WW'(p_odd);

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out  <= 1'b0;
      d_odd  <= '0;
      y_even <= '0;
      y_odd  <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        d_odd  <= p_odd;
        y_even <= w_even[YW-1:0];
        y_odd  <= w_odd[YW-1:0];
      end
    end
  end

  // wide results must fit the output width exactly
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    v_in |-> ((&w_even[WW-1:YW-1]) || !(|w_even[WW-1:YW-1])) &&
             ((&w_odd[WW-1:YW-1])  || !(|w_odd[WW-1:YW-1])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !v_in |=> $stable(y_even) && $stable(y_odd));

endmodule

// File: rtl/fir_two_parallel.sv
module fir_two_parallel
  import fir2p_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CW    = 10,
  parameter int NTAPS = 9,
  parameter logic [NTAPS*CW-1:0] COEFS = {NTAPS{CW'(1)}},
  localparam int YW = DW + CW + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] x_even,
  input  logic signed [DW-1:0] x_odd,
  output logic                 out_valid,
  output logic signed [YW-1:0] y_even,
  output logic signed [YW-1:0] y_odd
);
  localparam int T  = half_up(NTAPS);
  localparam int IW = DW + 1;
  localparam int SW = DW + CW + 3 + $clog2(T);

  logic signed [IW-1:0] lane_in  [3];
  logic signed [SW-1:0] lane_out [3];
  logic                 v1;
  logic [1:0]           since_rst;

  assign lane_in[SEL_EVEN] = IW'(x_even);
  assign lane_in[SEL_ODD]  = IW'(x_odd);
  assign lane_in[SEL_SUM]  = IW'(x_even) + IW'(x_odd);

  for (genvar g = 0; g < 3; g++) begin : g_sub
    fir2p_subfir #(
      .IW(IW), .CW(CW), .NTAPS(NTAPS), .SW(SW), .SEL(g), .COEFS(COEFS)
    ) u_sub (
      .clk      (clk),
      .rst      (rst),
      .shift_en (in_valid),
      .x_in     (lane_in[g]),
      .y_out    (lane_out[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
  end

  fir2p_recombine #(.SW(SW), .YW(YW)) u_post (
    .clk    (clk),
    .rst    (rst),
    .v_in   (v1),
    .p_even (lane_out[SEL_EVEN]),
    .p_odd  (lane_out[SEL_ODD]),
    .p_sum  (lane_out[SEL_SUM]),
    .v_out  (out_valid),
    .y_even (y_even),
    .y_odd  (y_odd)
  );

  // cycles since reset release, saturating; qualifies the latency check
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |-> (out_valid == $past(in_valid, 2)));

  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && y_even == '0 && y_odd == '0));

endmodule

// File: tb/fir_two_parallel_tb.sv
`timescale 1ns/1ps
module fir_two_parallel_tb_top;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int NT = 9;
  localparam int YW = DW + CW + $clog2(NT);
  localparam int HC [NT] = '{-512, 300, 511, -77, 120, -512, 45, 200, -3};
  localparam int MAXC = 4096;

  function automatic logic [NT*CW-1:0] pack_h();
    logic [NT*CW-1:0] r;
    r = '0;
    for (int i = 0; i < NT; i++) r[i*CW +: CW] = CW'(HC[i]);
    return r;
  endfunction
  localparam logic [NT*CW-1:0] HPACK = pack_h();

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] x_even = '0;
  logic signed [DW-1:0] x_odd  = '0;
  logic out_valid;
  logic signed [YW-1:0] y_even;
  logic signed [YW-1:0] y_odd;

  always #5 clk = ~clk;

  fir_two_parallel #(.DW(DW), .CW(CW), .NTAPS(NT), .COEFS(HPACK)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_even(x_even), .x_odd(x_odd),
    .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  longint samp  [MAXC];
  int    ns = 0;
  int    cyc = 0;
  bit    drv_v [MAXC];
  longint exp_e [MAXC];
  longint exp_o [MAXC];
  string tag_e [MAXC];
  string tag_o [MAXC];
  longint last_e = 0;
  longint last_o = 0;

  function automatic longint ref_y(input int n);
    longint s;
    s = 0;
    for (int i = 0; i < NT; i++) if (n - i >= 0) s += longint'(HC[i]) * samp[n-i];
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic step(input bit v, input int xe, input int xo, input string te, input string to);
    @(posedge clk);
    #2;
    in_valid = v;
    x_even   = DW'(xe);
    x_odd    = DW'(xo);
    if (v) begin
      samp[ns] = xe;
      samp[ns+1] = xo;
      last_e = ref_y(ns);
      last_o = ref_y(ns + 1);
      ns += 2;
    end
    drv_v[cyc] = v;
    exp_e[cyc] = last_e;
    exp_o[cyc] = last_o;
    tag_e[cyc] = v ? te : "R5";
    tag_o[cyc] = v ? to : "R5";
    @(negedge clk);
    if (cyc >= 2) begin
      chk(out_valid == drv_v[cyc-2], "R2", longint'(out_valid), longint'(drv_v[cyc-2]));
      chk(longint'(y_even) == exp_e[cyc-2], tag_e[cyc-2], longint'(y_even), exp_e[cyc-2]);
      chk(longint'(y_odd)  == exp_o[cyc-2], tag_o[cyc-2], longint'(y_odd),  exp_o[cyc-2]);
    end
    cyc++;
  endtask

  function automatic int rnd_s();
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    chk(longint'(y_even) == 0, "R1", longint'(y_even), 0);
    chk(longint'(y_odd) == 0,  "R1", longint'(y_odd), 0);

    // R6: unit sample on the even lane walks through the coefficients
    step(1, 1, 0, "R6", "R6");
    for (int i = 0; i < 6; i++) step(1, 0, 0, "R6", "R6");
    // R8: unit sample on the odd lane only
    step(1, 0, 1, "R8", "R8");
    for (int i = 0; i < 6; i++) step(1, 0, 0, "R8", "R8");
    // R8 with a gap right after the unit sample
    step(1, 0, 1, "R8", "R8");
    step(0, 0, 0, "R5", "R5");
    step(0, 0, 0, "R5", "R5");
    for (int i = 0; i < 5; i++) step(1, 0, 0, "R8", "R8");

    // R7: extremes, all minimum then all maximum then alternating
    for (int i = 0; i < 8; i++) step(1, -2048, -2048, "R7", "R7");
    for (int i = 0; i < 8; i++) step(1, 2047, 2047, "R7", "R7");
    for (int i = 0; i < 8; i++) step(1, -2048, 2047, "R7", "R7");

    // R3/R4/R5: random samples with random idle gaps
    for (int i = 0; i < 700; i++) begin
      if ($urandom_range(0, 3) == 0) begin
        int gap;
        gap = int'($urandom_range(1, 4));
        for (int g = 0; g < gap; g++) step(0, rnd_s(), rnd_s(), "R5", "R5");
      end
      step(1, rnd_s(), rnd_s(), "R3", "R4");
    end

    // drain: outputs must hold (R5)
    for (int i = 0; i < 4; i++) step(0, 0, 0, "R5", "R5");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(100000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule